// File: doc/BRIEF.md
# Serial Set-Sum Reduction Controller

This block adds up a stream of integer values that arrive one per clock cycle, where each value carries a set tag. Sets follow one another with no dead cycles between them. The block returns one total for each set, labelled with that set's tag. The adder inside it is pipelined with three stages, so partial sums from up to two sets are moving through it at the same moment. A controller with a fixed schedule keeps those partial sums apart. It needs only a two-entry input buffer and a one-entry output buffer, and it never stalls the source.

Every cycle, the controller sends exactly one of four operand pairs to the adder:
- PAIR: a buffered input plus the input arriving now.
- FEED: the input arriving now plus the partial sum leaving the adder.
- MERGE: the partial sum leaving the adder plus the output buffer.
- ZERO: an empty slot.

A segment begins at each boundary. A boundary is a tag change while valid stays high, a drop of valid, or a rise of valid. At each boundary the controller runs a nine-phase schedule that folds the old set's three circulating partial sums into one while it starts up the new set. Because the schedule is fixed, every segment, whether a set or an idle gap, must last at least 8 cycles. A shorter segment raises an error pulse.

Top module: `serial_set_reducer`

## Requirements
- R1: For every set of at least 8 values, the block emits exactly one result, tagged with the set's tag and equal to the sum of the set's values modulo 2^DATA_W.
- R2: `sum_valid` is high for exactly one cycle per set. It is visible in the ninth cycle after the cycle that carried the set's last value, which is the eighth cycle after the boundary cycle. `sum_valid` is never high in two consecutive cycles.
- R3: A set ends when the tag changes while `in_valid` stays high, or when `in_valid` falls. Values with the same tag that arrive after an idle gap form a new set with its own result.
- R4: The block accepts an input on every cycle and has no backpressure. Sets of length 8 or more, including back-to-back sets of exactly 8, all produce correct results.
- R5: If a segment (a set or an idle gap) lasts fewer than 8 cycles, `seg_err` is high for one cycle: the cycle after the boundary that cut the segment short. Results after that are unspecified until reset.
- R6: While reset is high and right after it, `sum_valid`, `seg_err`, `sum_id` and `sum_data` are all zero.
- R7: Each FEED or MERGE slot finds a valid adder output whose tag matches the set it serves: the incoming tag for FEED, the closing set's tag for MERGE.
- R8: No partial sum is dropped. Every valid adder output is consumed by FEED or MERGE, loaded into the output buffer, or emitted as a final result.
- R9: The input buffer is never written when it is full and never read when it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input value is present this cycle |
| in_id | input | ID_W | Set tag of the input value |
| in_data | input | DATA_W | Input value |
| sum_valid | output | 1 | One-cycle strobe for a finished set total |
| sum_id | output | ID_W | Tag of the finished set |
| sum_data | output | DATA_W | Total of the finished set |
| seg_err | output | 1 | Pulse: a segment was shorter than 8 cycles |

## Verification
Four properties are checked on every cycle, under the condition that no short segment has occurred since reset:
- each FEED or MERGE slot meets a partner with a matching tag;
- every valid adder output is used somewhere;
- the input buffer neither overflows nor underflows;
- a result strobe never lasts more than one cycle.

Whether each total is correct, carries the right tag and arrives on the right cycle can only be shown by the bench's scenarios: sets of exactly 8, idle gaps of exactly 8, the same tag appearing again after a gap, wrap-around sums, and random sets and gaps. The error pulse after a short set or a short gap is likewise shown only by those scenarios.

// File: rtl/serial_red_pkg.sv
package serial_red_pkg;
  // operand routing choices for the single adder slot
  typedef enum logic [1:0] {
    CFG_PAIR  = 2'd0,  // buffered input + current input
    CFG_FEED  = 2'd1,  // current input + adder output
    CFG_MERGE = 2'd2,  // adder output + output buffer
    CFG_ZERO  = 2'd3   // empty slot
  } route_e;

  localparam int unsigned ADD_STAGES = 3;   // schedule is built for this latency
  localparam int unsigned SEG_MIN    = 8;   // minimum segment length in cycles
  localparam int unsigned PH_W       = 4;   // phase counter width, holds 0..SEG_MIN
  localparam int unsigned HOLD_DEPTH = 2;   // input buffer entries
endpackage

// File: rtl/red_adder_pipe.sv
module red_adder_pipe #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_live,
  input  logic [ID_W-1:0]   op_tag,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              res_live,
  output logic [ID_W-1:0]   res_tag,
  output logic [DATA_W-1:0] res_sum
);
  // integer stand-in for a multi-stage adder; the tag and live bit ride along
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic              live;
    logic [ID_W-1:0]   tag;
    logic [DATA_W-1:0] val;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= op_live;
        tag <= op_tag;
        val <= op_a + op_b;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= g_stage[g-1].live;
        tag <= g_stage[g-1].tag;
        val <= g_stage[g-1].val;
      end
    end
  end

  assign res_live = g_stage[STAGES-1].live;
  assign res_tag  = g_stage[STAGES-1].tag;
  assign res_sum  = g_stage[STAGES-1].val;
endmodule

// File: rtl/red_hold_fifo.sv
module red_hold_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chk_en,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      if (push && !pop)      fill <= fill + CW'(1);
      else if (pop && !push) fill <= fill - CW'(1);
    end
  end

  assign head = mem[rd_ptr];

  // R9: buffer capacity respected
  assert_fifo_no_overflow_R9: assert property (@(posedge clk) disable iff (rst || !chk_en)
    (push && !pop) |-> (fill < CW'(DEPTH)));
  assert_fifo_no_underflow_R9: assert property (@(posedge clk) disable iff (rst || !chk_en)
    pop |-> (fill != '0));
endmodule

// File: rtl/red_sched.sv
module red_sched
  import serial_red_pkg::*;
#(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [ID_W-1:0] in_id,
  output route_e          route,
  output logic [ID_W-1:0] old_id,
  output logic            fifo_push,
  output logic            fifo_pop,
  output logic            ob_load,
  output logic            emit,
  output logic            seg_short
);
  localparam logic [PH_W-1:0] PH_SAT = PH_W'(SEG_MIN);

  logic            last_valid_q;
  logic [ID_W-1:0] last_id_q;
  logic [PH_W-1:0] phase_q, phase;
  logic            old_live_q, old_live;
  logic [ID_W-1:0] old_id_q;
  logic            boundary;

  assign boundary  = (in_valid != last_valid_q) || (in_valid && (in_id != last_id_q));
  assign phase     = boundary ? '0 : ((phase_q == PH_SAT) ? PH_SAT : phase_q + PH_W'(1));
  assign old_live  = boundary ? last_valid_q : old_live_q;
  assign old_id    = boundary ? last_id_q : old_id_q;
  assign seg_short = boundary && (phase_q < PH_W'(SEG_MIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      last_valid_q <= 1'b0;
      last_id_q    <= '0;
      phase_q      <= PH_SAT;
      old_live_q   <= 1'b0;
      old_id_q     <= '0;
    end else begin
      last_valid_q <= in_valid;
      last_id_q    <= in_id;
      phase_q      <= phase;
      old_live_q   <= old_live;
      old_id_q     <= old_id;
    end
  end

  // new set: buffer c1,c2 then pair with c3,c4; buffer c5; feed c6,c7; pair c5+c8
  // closing set: hold P1, merge with P2, hold P3, merge with P1+P2, emit at phase 7
  always_comb begin
    route     = CFG_ZERO;
    fifo_push = 1'b0;
    fifo_pop  = 1'b0;
    ob_load   = 1'b0;
    emit      = 1'b0;
    if (in_valid) begin
      case (phase)
        4'd0, 4'd1, 4'd4: fifo_push = 1'b1;
        4'd2, 4'd3, 4'd7: begin fifo_pop = 1'b1; route = CFG_PAIR; end
        4'd5, 4'd6, 4'd8: route = CFG_FEED;
        default: ;
      endcase
    end
    if (old_live) begin
      case (phase)
        4'd0, 4'd2: ob_load = 1'b1;
        4'd1, 4'd4: route   = CFG_MERGE;
        4'd7:       emit    = 1'b1;
        default: ;
      endcase
    end
  end

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (rst)
    phase_q <= PH_SAT);
endmodule

// File: rtl/serial_set_reducer.sv
module serial_set_reducer
  import serial_red_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DATA_W-1:0] in_data,
  output logic              sum_valid,
  output logic [ID_W-1:0]   sum_id,
  output logic [DATA_W-1:0] sum_data,
  output logic              seg_err
);
  route_e            route;
  logic [ID_W-1:0]   old_id;
  logic              fifo_push, fifo_pop, ob_load, emit, seg_short;
  logic [DATA_W-1:0] fifo_head, ob_q;
  logic              op_live;
  logic [ID_W-1:0]   op_tag;
  logic [DATA_W-1:0] op_a, op_b;
  logic              p_live;
  logic [ID_W-1:0]   p_tag;
  logic [DATA_W-1:0] p_sum;
  logic              fault_q, chk_en;

  assign chk_en = !(fault_q || seg_short);

  red_sched #(.ID_W(ID_W)) u_sched (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_id(in_id),
    .route(route), .old_id(old_id), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .ob_load(ob_load), .emit(emit), .seg_short(seg_short)
  );

  red_hold_fifo #(.W(DATA_W), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk(clk), .rst(rst), .chk_en(chk_en), .push(fifo_push), .pop(fifo_pop),
    .din(in_data), .head(fifo_head)
  );

  always_comb begin
    op_live = 1'b1;
    op_tag  = in_id;
    op_a    = '0;
    op_b    = '0;
    case (route)
      CFG_PAIR:  begin op_a = fifo_head; op_b = in_data; end
      CFG_FEED:  begin op_a = in_data;   op_b = p_sum;   end
      CFG_MERGE: begin op_a = ob_q;      op_b = p_sum;   op_tag = old_id; end
      default:   op_live = 1'b0;
    endcase
  end

  red_adder_pipe #(.DATA_W(DATA_W), .ID_W(ID_W), .STAGES(ADD_STAGES)) u_add (
    .clk(clk), .rst(rst), .op_live(op_live), .op_tag(op_tag), .op_a(op_a), .op_b(op_b),
    .res_live(p_live), .res_tag(p_tag), .res_sum(p_sum)
  );

  always_ff @(posedge clk) begin
    if (ob_load) ob_q <= p_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid <= 1'b0;
      sum_id    <= '0;
      sum_data  <= '0;
      seg_err   <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      sum_valid <= emit;
      if (emit) begin
        sum_id   <= old_id;
        sum_data <= p_sum;
      end
      seg_err <= seg_short;
      fault_q <= fault_q || seg_short;
    end
  end

  // R7: scheduled partners are present and belong to the right set
  assert_feed_partner_R7: assert property (@(posedge clk) disable iff (rst || !chk_en)
    (route == CFG_FEED) |-> (p_live && (p_tag == in_id)));
  assert_merge_partner_R7: assert property (@(posedge clk) disable iff (rst || !chk_en)
    (route == CFG_MERGE) |-> (p_live && (p_tag == old_id)));
  // R1: the emitted value is the closing set's last partial
  assert_emit_final_R1: assert property (@(posedge clk) disable iff (rst || !chk_en)
    emit |-> (p_live && (p_tag == old_id)));
  // R8: every adder output is consumed
  assert_no_drop_R8: assert property (@(posedge clk) disable iff (rst || !chk_en)
    p_live |-> ((route == CFG_FEED) || (route == CFG_MERGE) || ob_load || emit));
  // R2: result strobe is a single cycle
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    sum_valid |=> !sum_valid);
endmodule

// File: tb/sim_serial_set_reducer.sv
`timescale 1ns/1ps
module sim_serial_set_reducer;
  localparam int DW = 32;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [IW-1:0] in_id = '0;
  logic [DW-1:0] in_data = '0;
  logic          sum_valid;
  logic [IW-1:0] sum_id;
  logic [DW-1:0] sum_data;
  logic          seg_err;

  always #2 clk = ~clk;

  serial_set_reducer #(.DATA_W(DW), .ID_W(IW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_id(in_id), .in_data(in_data),
    .sum_valid(sum_valid), .sum_id(sum_id), .sum_data(sum_data), .seg_err(seg_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seg_cnt = 100;
  int err_at = -1;
  bit ignore = 0;
  bit last_v = 0;
  logic [IW-1:0] last_id = '0;
  logic [DW-1:0] acc = '0;
  logic [IW-1:0] q_id[$];
  logic [DW-1:0] q_sum[$];
  int            q_due[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic observe();
    if (err_at == cyc) check(seg_err == 1'b1, "R5", "short segment pulse", 32'(seg_err), 1);
    else if (!ignore && seg_err) check(0, "R5", "spurious error", 1, 0);
    if (ignore) return;
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      check(sum_valid == 1'b1, "R2", "result strobe timing", 32'(sum_valid), 1);
      check(sum_id == q_id[0], "R1", "result tag", 32'(sum_id), 32'(q_id[0]));
      check(sum_data == q_sum[0], "R1", "result sum", sum_data, q_sum[0]);
      void'(q_id.pop_front()); void'(q_sum.pop_front()); void'(q_due.pop_front());
    end else if (sum_valid) begin
      check(0, "R2", "unexpected strobe", 1, 0);
    end
  endtask

  // one cycle: sample outputs, then present the next input (R3 boundary model)
  task automatic tick(input bit v, input logic [IW-1:0] id, input logic [DW-1:0] d);
    bit bnd;
    @(negedge clk);
    cyc++;
    observe();
    bnd = (v != last_v) || (v && id != last_id);
    if (bnd) begin
      if (seg_cnt < 8) begin
        if (!ignore) err_at = cyc + 1;
        ignore = 1;
        q_id.delete(); q_sum.delete(); q_due.delete();
      end else if (last_v && !ignore) begin
        q_id.push_back(last_id); q_sum.push_back(acc); q_due.push_back(cyc + 8);
      end
      acc = '0;
      seg_cnt = 0;
    end
    if (seg_cnt < 100) seg_cnt++;
    if (v) acc = acc + d;
    in_valid = v;
    in_id    = v ? id : '0;
    in_data  = v ? d : '0;
    last_v   = v;
    last_id  = id;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_id = '0; in_data = '0;
    repeat (2) @(negedge clk);
    // R6: quiet outputs in reset
    check(sum_valid == 1'b0 && seg_err == 1'b0, "R6", "strobes in reset",
          {30'd0, sum_valid, seg_err}, 0);
    check(sum_id == '0 && sum_data == '0, "R6", "data in reset", sum_data | 32'(sum_id), 0);
    rst = 1'b0;
    last_v = 0; last_id = '0; acc = '0; seg_cnt = 100; ignore = 0; err_at = -1;
    q_id.delete(); q_sum.delete(); q_due.delete();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, '0, '0);
  endtask

  task automatic send_set(input logic [IW-1:0] id, input int len, input logic [DW-1:0] base,
                          input bit rnd);
    for (int i = 0; i < len; i++) tick(1, id, rnd ? $urandom : base + DW'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [IW-1:0] id;
    void'($urandom(32'd4242));
    do_reset();
    // R4: back-to-back sets of exactly 8 right after reset
    send_set(8'd3, 8, 32'd1, 0);
    send_set(8'd4, 8, 32'd10, 0);
    send_set(8'd7, 8, 32'd100, 0);
    idle(10);
    // R1: sum wraps modulo 2^32
    send_set(8'd9, 10, 32'hFFFF_FFF0, 0);
    idle(8);
    // R3: same tag before and after an exact 8-cycle gap gives two results
    send_set(8'd5, 9, 32'd20, 0);
    idle(8);
    send_set(8'd5, 8, 32'd40, 0);
    send_set(8'd6, 12, 32'd0, 1);
    idle(12);
    // random sets and gaps
    id = 8'd11;
    for (int s = 0; s < 60; s++) begin
      int len, gap;
      len = 8 + int'($urandom % 17);
      id  = id + IW'(1 + $urandom % 200);
      send_set(id, len, '0, 1);
      if ($urandom % 4 == 0) begin
        gap = 8 + int'($urandom % 4);
        idle(gap);
      end
    end
    idle(14);
    // R1: every expected result came out
    check(q_due.size() == 0, "R1", "pending results after drain", 32'(q_due.size()), 0);

    // R5: set shorter than 8
    send_set(8'd20, 8, 32'd1, 0);
    send_set(8'd21, 5, 32'd1, 0);
    send_set(8'd22, 9, 32'd1, 0);
    idle(10);
    do_reset();
    // R5: idle gap shorter than 8
    send_set(8'd30, 8, 32'd2, 0);
    idle(3);
    send_set(8'd31, 9, 32'd2, 0);
    idle(10);
    do_reset();
    // recovery after reset (R6, R1)
    send_set(8'd40, 11, 32'd7, 0);
    idle(12);
    check(q_due.size() == 0, "R1", "result after recovery", 32'(q_due.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule